// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is the control state machine of a small word-addressed processor with sixteen 32-bit registers and 20-bit instructions. The datapath sits outside the block. It has a data bus and an address bus, a register file with two read ports, a program counter, an instruction register, an ALU result register, a one-bit condition register and a slow memory. Each cycle the sequencer reads the instruction register and the condition bit. From its own state it then raises the bus-drive enables, the latch enables and the mux selects for that cycle.

Every instruction starts with a five-cycle fetch. The fetch reads memory at the PC, waits one cycle, latches the instruction and writes back PC+1. The execute states for the opcode follow. The memory timing is respected by construction: read data is used two cycles after the read is issued, and a write is always followed by a cycle with no memory activity. A halt instruction parks the machine in a quiet state until reset.

Top module: `mc_seq_ctrl`

## Requirements
- R1: `rst_n` is a synchronous, active-low reset. After any clock edge with `rst_n` low, the outputs show the first fetch cycle: only `pc_drv_addr` and `mem_rd` are high, and `halted` is low.
- R2: Fetch takes five cycles:
  - read at the PC;
  - an idle cycle;
  - `mem_drv_data` with `ir_we`;
  - PC on the address bus plus constant 1 (`alu_lsel`=00, `alu_op`=01) into the result register;
  - result on the data bus with `pc_wr`.
  The execute state is chosen from opcode bits 19:16 in that fifth cycle.
- R3: Fields are opcode [19:16], A [15:12], B [11:8], D [3:0] and the 8-bit signed offset/immediate [7:0].
  - Opcode 0000 writes A+B to D.
  - Opcode 0001 writes ~(A&B) to D.
  - Each takes 2 execute cycles.
- R4: Opcode 0010 loads B from memory word A+sext(offset). It takes 4 execute cycles, with one idle cycle between the read and the use of the data.
- R5: Opcode 0011 stores B to memory word A+sext(offset). It takes 3 execute cycles, the last with no memory control.
- R6: Opcode 0100 compares A and B:
  - The compare cycle latches the OR of (A−B) into the condition register.
  - Two cycles later, the conditional PC write loads PC+1+sext(offset), but only if that bit is 0.
  - It takes 3 execute cycles.
- R7: Opcode 0101 writes PC+1 to B and then loads the PC from A, in that order, so A equal to B continues at PC+1. It takes 2 execute cycles.
- R8: Each of these takes 2 execute cycles:
  - Opcode 1000 writes A+1 to D.
  - Opcode 1001 writes A−1 to D.
  - Opcode 1010 writes A+sext(imm) to B.
- R9: Opcode 1011 writes B + memory word (A+sext(offset)) to B. The memory word is taken from the address bus. It takes 5 execute cycles.
- R10: Opcode 0111 and opcodes 1100–1111 change no register. The next fetch starts right after the fetch, 5 cycles per instruction.
- R11: Opcode 0110 raises `halted` and keeps it high with every enable low until reset.
- R12: Memory timing:
  - `mem_drv_data` or `mem_drv_addr` is asserted only two cycles after `mem_rd`, with `mem_rd` low in between.
  - A cycle with `mem_wr` is followed by one with no memory control.
- R13: At most one data-bus driver (PC, IR offset, result register, memory, read port 1) and at most one address-bus driver (PC, result register, memory, read port 2) are enabled per cycle.
  - Encodings: `alu_op` 00 none, 01 add, 10 subtract (address bus − left operand), 11 nand. `alu_lsel` 00 constant 1, 01 data bus, 10 sign-extended low byte of the data bus.
  - `rd1_sel` 0 = A, 1 = B. `wr_sel` 0 = B, 1 = D.
  - Read port 2 always indexes A. The PC and registers load from the data bus, and the ALU's right operand is the address bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_word | input | 20 | Instruction register contents |
| cond_bit | input | 1 | Condition register (OR of last compare result) |
| pc_wr | output | 1 | Unconditional PC load from data bus |
| pc_wr_cond | output | 1 | PC load from data bus when cond_bit is 0 |
| pc_drv_data | output | 1 | PC onto data bus |
| pc_drv_addr | output | 1 | PC onto address bus |
| ir_we | output | 1 | Instruction register load from data bus |
| ir_drv | output | 1 | Sign-extended offset field onto data bus |
| alur_we | output | 1 | ALU result register load |
| alur_drv_data | output | 1 | Result register onto data bus |
| alur_drv_addr | output | 1 | Result register onto address bus |
| cr_we | output | 1 | Condition register load |
| mem_wr | output | 1 | Memory write (address and data buffered) |
| mem_rd | output | 1 | Memory read start (address buffered) |
| mem_drv_data | output | 1 | Memory word onto data bus |
| mem_drv_addr | output | 1 | Memory word onto address bus |
| rf_rd1_en | output | 1 | Read port 1 onto data bus |
| rf_rd2_en | output | 1 | Read port 2 (field A) onto address bus |
| rf_we | output | 1 | Register write from data bus |
| alu_op | output | 2 | ALU operation |
| alu_lsel | output | 2 | ALU left operand select |
| rd1_sel | output | 1 | Read port 1 index field |
| wr_sel | output | 1 | Write port index field |
| halted | output | 1 | Machine halted |

## Verification
Several rules are checked by the bound assertions on every cycle:
- bus exclusivity;
- the memory gap after a read and the idle cycle after a write;
- the fetch tail that follows an instruction latch;
- the two-cycle link from compare to conditional PC write;
- the link-then-jump order;
- the quiet, sticky halt state.

A behavioural datapath in the bench runs each instruction from a vector table. Only those runs can show the rest:
- that the enables add up to the right arithmetic result;
- the memory word each access reaches;
- a taken, untaken or backward branch target;
- that jalr with A equal to B lands on PC+1;
- the cycle count of each opcode;
- that unused opcodes leave the registers untouched.

// File: rtl/mcs_pkg.sv
// Shared types of the multicycle sequencer: opcodes, ALU controls, states
// and the packed control word. Assumes a 4-bit opcode field.
package mcs_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_NAND = 4'b0001,
        OP_LW   = 4'b0010,
        OP_SW   = 4'b0011,
        OP_BEQ  = 4'b0100,
        OP_JALR = 4'b0101,
        OP_HALT = 4'b0110,
        OP_NOOP = 4'b0111,
        OP_INC  = 4'b1000,
        OP_DEC  = 4'b1001,
        OP_ADDI = 4'b1010,
        OP_ADDM = 4'b1011
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_NONE = 2'b00,
        ALU_ADD  = 2'b01,
        ALU_SUB  = 2'b10,
        ALU_NAND = 2'b11
    } alu_op_e;

    typedef enum logic [1:0] {
        LSEL_ONE  = 2'b00,
        LSEL_BUS  = 2'b01,
        LSEL_SEXT = 2'b10
    } lsel_e;

    typedef enum logic [4:0] {
        S_F_ADDR, S_F_WAIT, S_F_LATCH, S_F_INC, S_F_PCWR,
        S_ADD_CALC, S_NAND_CALC, S_INC_CALC, S_DEC_CALC, S_ADDI_CALC,
        S_EA, S_WB_D, S_WB_B,
        S_MEM_RD, S_MEM_WAIT, S_LW_WB, S_AM_SUM,
        S_SW_WR, S_SW_IDLE,
        S_BEQ_CMP, S_BEQ_TGT, S_BEQ_WR,
        S_JALR_LINK, S_JALR_JMP,
        S_HALT
    } state_e;

    typedef struct packed {
        logic    pc_wr;
        logic    pc_wr_cond;
        logic    pc_drv_data;
        logic    pc_drv_addr;
        logic    ir_we;
        logic    ir_drv;
        logic    alur_we;
        logic    alur_drv_data;
        logic    alur_drv_addr;
        logic    cr_we;
        logic    mem_wr;
        logic    mem_rd;
        logic    mem_drv_data;
        logic    mem_drv_addr;
        logic    rf_rd1_en;
        logic    rf_rd2_en;
        logic    rf_we;
        alu_op_e alu_op;
        lsel_e   alu_lsel;
        logic    rd1_sel;   // 0: field A, 1: field B
        logic    wr_sel;    // 0: field B, 1: field D
    } ctrl_t;

endpackage

// File: rtl/mcs_opdecode.sv
// Opcode decoder: maps the opcode field of the instruction word to the first
// execute state and to the branch points shared by the memory opcodes.
// Assumes the opcode is the top OPC_W bits of the word; the other bits are
// not needed for sequencing.
module mcs_opdecode
    import mcs_pkg::*;
#(
    parameter int OPC_LSB = 16,
    localparam int IR_W   = OPC_LSB + OPC_W
) (
    input  logic [IR_W-1:0] ir_word,
    output state_e          entry_state,
    output state_e          ea_next,
    output state_e          wait_next
);

    logic [OPC_W-1:0] opc;
    logic             unused_fields;

    assign opc           = ir_word[OPC_LSB +: OPC_W];
    assign unused_fields = ^ir_word[OPC_LSB-1:0];

    // First execute state per opcode; unassigned opcodes behave as noop.
    always_comb begin
        unique case (opc)
            OP_ADD:  entry_state = S_ADD_CALC;
            OP_NAND: entry_state = S_NAND_CALC;
            OP_LW,
            OP_SW,
            OP_ADDM: entry_state = S_EA;
            OP_BEQ:  entry_state = S_BEQ_CMP;
            OP_JALR: entry_state = S_JALR_LINK;
            OP_HALT: entry_state = S_HALT;
            OP_INC:  entry_state = S_INC_CALC;
            OP_DEC:  entry_state = S_DEC_CALC;
            OP_ADDI: entry_state = S_ADDI_CALC;
            default: entry_state = S_F_ADDR;
        endcase
    end

    // Branch after the effective address: store writes, the others read.
    always_comb ea_next = (opc == OP_SW) ? S_SW_WR : S_MEM_RD;

    // Branch after the read wait: memory-add sums, load writes back.
    always_comb wait_next = (opc == OP_ADDM) ? S_AM_SUM : S_LW_WB;

endmodule

// File: rtl/mcs_state_seq.sv
// State register and next-state logic. Fetch is a fixed chain; the last
// fetch state dispatches on the decoded entry state. Assumes the instruction
// register stays stable outside the fetch latch cycle.
module mcs_state_seq
    import mcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  state_e entry_state,
    input  state_e ea_next,
    input  state_e wait_next,
    output state_e state_q
);

    state_e state_d;

    // Next-state selection for every state.
    always_comb begin
        unique case (state_q)
            S_F_ADDR:    state_d = S_F_WAIT;
            S_F_WAIT:    state_d = S_F_LATCH;
            S_F_LATCH:   state_d = S_F_INC;
            S_F_INC:     state_d = S_F_PCWR;
            S_F_PCWR:    state_d = entry_state;
            S_ADD_CALC,
            S_NAND_CALC,
            S_INC_CALC,
            S_DEC_CALC:  state_d = S_WB_D;
            S_ADDI_CALC: state_d = S_WB_B;
            S_EA:        state_d = ea_next;
            S_MEM_RD:    state_d = S_MEM_WAIT;
            S_MEM_WAIT:  state_d = wait_next;
            S_AM_SUM:    state_d = S_WB_B;
            S_SW_WR:     state_d = S_SW_IDLE;
            S_BEQ_CMP:   state_d = S_BEQ_TGT;
            S_BEQ_TGT:   state_d = S_BEQ_WR;
            S_JALR_LINK: state_d = S_JALR_JMP;
            S_HALT:      state_d = S_HALT;
            default:     state_d = S_F_ADDR;
        endcase
    end

    // State register with synchronous active-low reset to the first fetch state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_F_ADDR;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/mcs_ctrl_gen.sv
// Control word generator: a pure function of the state (Moore outputs), so
// no enable depends on the instruction word within a cycle. Each state
// enables at most one driver per bus.
module mcs_ctrl_gen
    import mcs_pkg::*;
(
    input  state_e state_q,
    output ctrl_t  ctrl,
    output logic   halted
);

    // Enables and selects for the current state.
    always_comb begin
        ctrl = '0;
        unique case (state_q)
            S_F_ADDR: begin
                ctrl.pc_drv_addr = 1'b1;
                ctrl.mem_rd      = 1'b1;
            end
            S_F_LATCH: begin
                ctrl.mem_drv_data = 1'b1;
                ctrl.ir_we        = 1'b1;
            end
            S_F_INC: begin
                ctrl.pc_drv_addr = 1'b1;
                ctrl.alu_lsel    = LSEL_ONE;
                ctrl.alu_op      = ALU_ADD;
                ctrl.alur_we     = 1'b1;
            end
            S_F_PCWR: begin
                ctrl.alur_drv_data = 1'b1;
                ctrl.pc_wr         = 1'b1;
            end
            S_ADD_CALC, S_NAND_CALC: begin
                ctrl.rf_rd1_en = 1'b1;
                ctrl.rd1_sel   = 1'b1;
                ctrl.rf_rd2_en = 1'b1;
                ctrl.alu_lsel  = LSEL_BUS;
                ctrl.alu_op    = (state_q == S_ADD_CALC) ? ALU_ADD : ALU_NAND;
                ctrl.alur_we   = 1'b1;
            end
            S_INC_CALC, S_DEC_CALC: begin
                ctrl.rf_rd2_en = 1'b1;
                ctrl.alu_lsel  = LSEL_ONE;
                ctrl.alu_op    = (state_q == S_INC_CALC) ? ALU_ADD : ALU_SUB;
                ctrl.alur_we   = 1'b1;
            end
            S_ADDI_CALC, S_EA: begin
                ctrl.ir_drv    = 1'b1;
                ctrl.rf_rd2_en = 1'b1;
                ctrl.alu_lsel  = LSEL_SEXT;
                ctrl.alu_op    = ALU_ADD;
                ctrl.alur_we   = 1'b1;
            end
            S_WB_D: begin
                ctrl.alur_drv_data = 1'b1;
                ctrl.rf_we         = 1'b1;
                ctrl.wr_sel        = 1'b1;
            end
            S_WB_B: begin
                ctrl.alur_drv_data = 1'b1;
                ctrl.rf_we         = 1'b1;
            end
            S_MEM_RD: begin
                ctrl.alur_drv_addr = 1'b1;
                ctrl.mem_rd        = 1'b1;
            end
            S_LW_WB: begin
                ctrl.mem_drv_data = 1'b1;
                ctrl.rf_we        = 1'b1;
            end
            S_AM_SUM: begin
                ctrl.mem_drv_addr = 1'b1;
                ctrl.rf_rd1_en    = 1'b1;
                ctrl.rd1_sel      = 1'b1;
                ctrl.alu_lsel     = LSEL_BUS;
                ctrl.alu_op       = ALU_ADD;
                ctrl.alur_we      = 1'b1;
            end
            S_SW_WR: begin
                ctrl.alur_drv_addr = 1'b1;
                ctrl.rf_rd1_en     = 1'b1;
                ctrl.rd1_sel       = 1'b1;
                ctrl.mem_wr        = 1'b1;
            end
            S_BEQ_CMP: begin
                ctrl.rf_rd1_en = 1'b1;
                ctrl.rd1_sel   = 1'b1;
                ctrl.rf_rd2_en = 1'b1;
                ctrl.alu_lsel  = LSEL_BUS;
                ctrl.alu_op    = ALU_SUB;
                ctrl.cr_we     = 1'b1;
            end
            S_BEQ_TGT: begin
                ctrl.ir_drv      = 1'b1;
                ctrl.pc_drv_addr = 1'b1;
                ctrl.alu_lsel    = LSEL_SEXT;
                ctrl.alu_op      = ALU_ADD;
                ctrl.alur_we     = 1'b1;
            end
            S_BEQ_WR: begin
                ctrl.alur_drv_data = 1'b1;
                ctrl.pc_wr_cond    = 1'b1;
            end
            S_JALR_LINK: begin
                ctrl.pc_drv_data = 1'b1;
                ctrl.rf_we       = 1'b1;
            end
            S_JALR_JMP: begin
                ctrl.rf_rd1_en = 1'b1;
                ctrl.pc_wr     = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

    // Halt flag is the halt state itself.
    always_comb halted = (state_q == S_HALT);

endmodule

// File: rtl/mc_seq_ctrl.sv
// Top of the multicycle sequencer. Ties the opcode decoder, the state
// sequencer and the control generator together and flattens the control
// word onto ports. Assumes an external two-bus datapath and a memory whose
// read data is usable two cycles after the read starts.
module mc_seq_ctrl
    import mcs_pkg::*;
#(
    parameter int OPC_LSB = 16,
    localparam int IR_W   = OPC_LSB + OPC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IR_W-1:0] ir_word,
    input  logic            cond_bit,
    output logic            pc_wr,
    output logic            pc_wr_cond,
    output logic            pc_drv_data,
    output logic            pc_drv_addr,
    output logic            ir_we,
    output logic            ir_drv,
    output logic            alur_we,
    output logic            alur_drv_data,
    output logic            alur_drv_addr,
    output logic            cr_we,
    output logic            mem_wr,
    output logic            mem_rd,
    output logic            mem_drv_data,
    output logic            mem_drv_addr,
    output logic            rf_rd1_en,
    output logic            rf_rd2_en,
    output logic            rf_we,
    output logic [1:0]      alu_op,
    output logic [1:0]      alu_lsel,
    output logic            rd1_sel,
    output logic            wr_sel,
    output logic            halted
);

    state_e entry_state;
    state_e ea_next;
    state_e wait_next;
    state_e state_q;
    ctrl_t  ctrl;
    logic   unused_cond;

    // The condition bit gates the PC write inside the datapath, not here.
    assign unused_cond = cond_bit;

    mcs_opdecode #(.OPC_LSB(OPC_LSB)) u_dec (
        .ir_word     (ir_word),
        .entry_state (entry_state),
        .ea_next     (ea_next),
        .wait_next   (wait_next)
    );

    mcs_state_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .entry_state (entry_state),
        .ea_next     (ea_next),
        .wait_next   (wait_next),
        .state_q     (state_q)
    );

    mcs_ctrl_gen u_gen (
        .state_q (state_q),
        .ctrl    (ctrl),
        .halted  (halted)
    );

    // Flatten the control word onto the port list.
    always_comb begin
        pc_wr         = ctrl.pc_wr;
        pc_wr_cond    = ctrl.pc_wr_cond;
        pc_drv_data   = ctrl.pc_drv_data;
        pc_drv_addr   = ctrl.pc_drv_addr;
        ir_we         = ctrl.ir_we;
        ir_drv        = ctrl.ir_drv;
        alur_we       = ctrl.alur_we;
        alur_drv_data = ctrl.alur_drv_data;
        alur_drv_addr = ctrl.alur_drv_addr;
        cr_we         = ctrl.cr_we;
        mem_wr        = ctrl.mem_wr;
        mem_rd        = ctrl.mem_rd;
        mem_drv_data  = ctrl.mem_drv_data;
        mem_drv_addr  = ctrl.mem_drv_addr;
        rf_rd1_en     = ctrl.rf_rd1_en;
        rf_rd2_en     = ctrl.rf_rd2_en;
        rf_we         = ctrl.rf_we;
        alu_op        = ctrl.alu_op;
        alu_lsel      = ctrl.alu_lsel;
        rd1_sel       = ctrl.rd1_sel;
        wr_sel        = ctrl.wr_sel;
    end

endmodule

// File: rtl/mcs_seq_chk.sv
// Protocol checker bound to the sequencer top: bus exclusivity, memory
// timing, fetch tail, branch and jump ordering, and halt behaviour.
module mcs_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_drv_data,
    input logic       pc_drv_addr,
    input logic       ir_we,
    input logic       ir_drv,
    input logic       alur_we,
    input logic       alur_drv_data,
    input logic       alur_drv_addr,
    input logic       cr_we,
    input logic       mem_wr,
    input logic       mem_rd,
    input logic       mem_drv_data,
    input logic       mem_drv_addr,
    input logic       rf_rd1_en,
    input logic       rf_rd2_en,
    input logic       rf_we,
    input logic [1:0] alu_op,
    input logic [1:0] alu_lsel,
    input logic       rd1_sel,
    input logic       halted
);

    logic any_en;
    assign any_en = pc_wr | pc_wr_cond | pc_drv_data | pc_drv_addr | ir_we | ir_drv |
                    alur_we | alur_drv_data | alur_drv_addr | cr_we | mem_wr | mem_rd |
                    mem_drv_data | mem_drv_addr | rf_rd1_en | rf_rd2_en | rf_we;

    assert_reset_fetch_R1: assert property (@(posedge clk)
        !rst_n |=> (mem_rd && pc_drv_addr && !halted));

    assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> (alur_we && pc_drv_addr && alu_lsel == 2'b00 && alu_op == 2'b01));

    assert_fetch_pcwr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> ##1 (pc_wr && alur_drv_data));

    assert_beq_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |-> $past(cr_we, 2));

    assert_jalr_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && pc_drv_data) |=> (pc_wr && rf_rd1_en && !rd1_sel));

    assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !any_en);

    assert_read_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_drv_data || mem_drv_addr) |-> ($past(mem_rd, 2) && !$past(mem_rd, 1)));

    assert_write_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !(mem_rd || mem_wr || mem_drv_data || mem_drv_addr));

    assert_dbus_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_drv_data, ir_drv, alur_drv_data, mem_drv_data, rf_rd1_en}) <= 1);

    assert_abus_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({pc_drv_addr, alur_drv_addr, mem_drv_addr, rf_rd2_en}) <= 1);

endmodule

bind mc_seq_ctrl mcs_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pc_wr         (pc_wr),
    .pc_wr_cond    (pc_wr_cond),
    .pc_drv_data   (pc_drv_data),
    .pc_drv_addr   (pc_drv_addr),
    .ir_we         (ir_we),
    .ir_drv        (ir_drv),
    .alur_we       (alur_we),
    .alur_drv_data (alur_drv_data),
    .alur_drv_addr (alur_drv_addr),
    .cr_we         (cr_we),
    .mem_wr        (mem_wr),
    .mem_rd        (mem_rd),
    .mem_drv_data  (mem_drv_data),
    .mem_drv_addr  (mem_drv_addr),
    .rf_rd1_en     (rf_rd1_en),
    .rf_rd2_en     (rf_rd2_en),
    .rf_we         (rf_we),
    .alu_op        (alu_op),
    .alu_lsel      (alu_lsel),
    .rd1_sel       (rd1_sel),
    .halted        (halted)
);

// File: tb/mc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module mc_seq_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] ir_word;
    logic        cond_bit;
    logic pc_wr, pc_wr_cond, pc_drv_data, pc_drv_addr, ir_we, ir_drv;
    logic alur_we, alur_drv_data, alur_drv_addr, cr_we, mem_wr, mem_rd;
    logic mem_drv_data, mem_drv_addr, rf_rd1_en, rf_rd2_en, rf_we;
    logic [1:0] alu_op, alu_lsel;
    logic rd1_sel, wr_sel, halted;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    mc_seq_ctrl u_mc_seq_ctrl (.*);

    // Behavioural two-bus datapath model.
    logic [31:0] rf [16];
    logic [31:0] mem [32];
    logic [31:0] pc, alur, dbus, abus, left, alu_y;
    logic        cr;
    logic [4:0]  mab, wa;
    logic [31:0] wd;
    logic        wr_pend;
    logic        dp_load = 1'b1;
    logic [19:0] vec_instr = '0;

    function automatic logic [31:0] sx8(input logic [7:0] v);
        return {{24{v[7]}}, v};
    endfunction

    assign ir_word  = ir_word_q;
    logic [19:0] ir_word_q;
    assign cond_bit = cr;

    always_comb begin
        dbus = '0;
        if (pc_drv_data)   dbus = pc;
        if (ir_drv)        dbus = sx8(ir_word_q[7:0]);
        if (alur_drv_data) dbus = alur;
        if (mem_drv_data)  dbus = mem[mab];
        if (rf_rd1_en)     dbus = rf[rd1_sel ? ir_word_q[11:8] : ir_word_q[15:12]];
        abus = '0;
        if (pc_drv_addr)   abus = pc;
        if (alur_drv_addr) abus = alur;
        if (mem_drv_addr)  abus = mem[mab];
        if (rf_rd2_en)     abus = rf[ir_word_q[15:12]];
        case (alu_lsel)
            2'b00:   left = 32'd1;
            2'b01:   left = dbus;
            default: left = sx8(dbus[7:0]);
        endcase
        case (alu_op)
            2'b01:   alu_y = abus + left;
            2'b10:   alu_y = abus - left;
            2'b11:   alu_y = ~(abus & left);
            default: alu_y = '0;
        endcase
    end

    always @(posedge clk) begin
        if (dp_load) begin
            for (int i = 0; i < 32; i++) mem[i] <= 32'd100 + i;
            mem[0] <= {12'h0, vec_instr};
            for (int i = 0; i < 16; i++) rf[i] <= i;
            rf[1] <= 32'd5; rf[2] <= 32'd7; rf[3] <= 32'hFFFF_FFFE;
            rf[4] <= 32'd10; rf[5] <= 32'd12;
            pc <= '0; alur <= '0; cr <= 1'b0; ir_word_q <= '0;
            mab <= '0; wa <= '0; wd <= '0; wr_pend <= 1'b0;
        end else begin
            if (wr_pend) mem[wa] <= wd;
            wr_pend <= mem_wr;
            if (mem_wr) begin wa <= abus[4:0]; wd <= dbus; end
            if (mem_rd) mab <= abus[4:0];
            if (ir_we) ir_word_q <= dbus[19:0];
            if (alur_we) alur <= alu_y;
            if (cr_we) cr <= |alu_y;
            if (rf_we) rf[wr_sel ? ir_word_q[3:0] : ir_word_q[11:8]] <= dbus;
            if (pc_wr || (pc_wr_cond && !cr)) pc <= dbus;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // kind: 0 register, 1 memory word, 2 next PC
    typedef struct packed {
        logic [19:0] instr;
        logic [1:0]  kind;
        logic [4:0]  idx;
        logic [31:0] exp;
        logic [7:0]  cyc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{20'h01206, 2'd0, 5'd6, 32'd12,         8'd7,  4'd3},  // R3 add
        '{20'h11207, 2'd0, 5'd7, 32'hFFFF_FFFA,  8'd7,  4'd3},  // R3 nand
        '{20'h21804, 2'd0, 5'd8, 32'd109,        8'd9,  4'd4},  // R4 load, positive offset
        '{20'h249FE, 2'd0, 5'd9, 32'd108,        8'd9,  4'd4},  // R4 load, negative offset
        '{20'h31201, 2'd1, 5'd6, 32'd7,          8'd8,  4'd5},  // R5 store
        '{20'h41104, 2'd2, 5'd0, 32'd5,          8'd8,  4'd6},  // R6 taken
        '{20'h41204, 2'd2, 5'd0, 32'd1,          8'd8,  4'd6},  // R6 not taken
        '{20'h400FD, 2'd2, 5'd0, 32'hFFFF_FFFE,  8'd8,  4'd6},  // R6 backward
        '{20'h55600, 2'd0, 5'd6, 32'd1,          8'd7,  4'd7},  // R7 link
        '{20'h55600, 2'd2, 5'd0, 32'd12,         8'd7,  4'd7},  // R7 jump
        '{20'h56600, 2'd2, 5'd0, 32'd1,          8'd7,  4'd7},  // R7 A equals B
        '{20'h81008, 2'd0, 5'd8, 32'd6,          8'd7,  4'd8},  // R8 inc
        '{20'h90007, 2'd0, 5'd7, 32'hFFFF_FFFF,  8'd7,  4'd8},  // R8 dec
        '{20'hA1680, 2'd0, 5'd6, 32'hFFFF_FF85,  8'd7,  4'd8},  // R8 addi -128
        '{20'hB1202, 2'd0, 5'd2, 32'd114,        8'd10, 4'd9},  // R9 addm
        '{20'h71206, 2'd0, 5'd6, 32'd6,          8'd5,  4'd10}, // R10 noop
        '{20'hC1206, 2'd0, 5'd6, 32'd6,          8'd5,  4'd10}, // R10 unused 1100
        '{20'hF1206, 2'd2, 5'd0, 32'd1,          8'd5,  4'd10}, // R10 unused 1111
        '{20'h70000, 2'd2, 5'd0, 32'd1,          8'd5,  4'd2}   // R2 fetch PC+1
    };

    task automatic start_run(input logic [19:0] instr);
        @(negedge clk);
        rst_n = 1'b0; dp_load = 1'b1; vec_instr = instr;
        repeat (2) @(negedge clk);
        rst_n = 1'b1; dp_load = 1'b0;
    endtask

    initial begin
        // R1: state during reset
        start_run(20'h70000);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_rd && pc_drv_addr && !halted && !ir_we && !rf_we && !pc_wr && !mem_wr,
              "R1", "reset outputs", {mem_rd, pc_drv_addr, halted}, 32'h6);

        for (int v = 0; v < NV; v++) begin
            int cyc;
            logic [31:0] nxt, got;
            string rq;
            start_run(VECS[v].instr);
            cyc = 0;
            do begin
                @(negedge clk);
                cyc++;
            end while (!(mem_rd && pc_drv_addr) && cyc < 40);
            nxt = abus;
            rq = $sformatf("R%0d", VECS[v].req);
            check(cyc == VECS[v].cyc, rq, $sformatf("cycles vec %0d", v), cyc, VECS[v].cyc);
            case (VECS[v].kind)
                2'd0:    got = rf[VECS[v].idx[3:0]];
                2'd1:    got = mem[VECS[v].idx];
                default: got = nxt;
            endcase
            check(got == VECS[v].exp, rq, $sformatf("result vec %0d", v), got, VECS[v].exp);
        end

        // R12: read data reaches the register only after the wait cycle (lw timing)
        start_run(20'h21804);
        repeat (8) @(negedge clk);
        check(rf[8] == 32'd8, "R12", "load not yet written", rf[8], 32'd8);

        // R11: halt raises halted after fetch and stays quiet
        start_run(20'h60000);
        repeat (5) @(negedge clk);
        check(halted == 1'b1, "R11", "halted raised", halted, 1);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(halted && !mem_rd && !pc_wr && !rf_we && !pc_drv_addr, "R11", "halt quiet",
                  {halted, mem_rd, pc_wr, rf_we}, 32'h8);
        end
        check(pc == 32'd1, "R11", "pc frozen", pc, 1);

        // R1: reset leaves the halt state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!halted && mem_rd && pc_drv_addr, "R1", "reset from halt",
              {halted, mem_rd, pc_drv_addr}, 32'h3);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R2 watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule